// File: doc/BRIEF.md
# PWM Action Qualifier with Shadowed Software Force

This block sits after a PWM time base and turns its event strobes into two output pins, A and B. On every cycle where the prescaled tick is high it looks at the events reported on that tick: counter at zero, counter at period, compare-A matched while counting up, and compare-B matched while counting up. For each output, a per-event 2-bit code in that output's action register says whether to leave the pin alone, drive it low, drive it high or toggle it. The pins change only on ticks.

Software can also hold either pin at a fixed level with a continuous force. Force values are written into a shadow copy. The shadow moves into the active force at a reload point chosen by a separate select field: a zero tick, a period tick, either of these, or any tick. While a force is active it takes priority over every event action.

Mapping the zero and period events to "high" and the compare event to "low" gives a normal-polarity edge-aligned PWM wave. Swapping high and low in that mapping gives the inverted wave.

Top module: `pwmActionQual`

## Requirements
- R1: After reset both outputs are low, both active and shadow force codes are 00 (no force), every action field is 00, and the reload select is 00 (load on zero).
- R2: Action code 00 leaves the output unchanged, 01 drives it low, 10 drives it high and 11 inverts it. Actions are applied only in a cycle where `tick` is high. Event strobes without `tick` have no effect.
- R3: Write address 0 holds the action fields of output A and address 1 those of output B. In each, bits 1:0 are the zero action, bits 3:2 the period action, bits 5:4 the compare-A-up action and bits 9:8 the compare-B-up action. All other bits are ignored.
- R4: When several events arrive on one tick, the event with the highest priority whose action code is not 00 decides. The order from highest to lowest is period, zero, compare-B, compare-A.
- R5: Write address 2 loads the shadow force, with bits 1:0 for output A and bits 3:2 for output B. Code 01 forces low, 10 forces high, and 00 or 11 mean no force. On each tick an active force sets the pin and overrides every event action.
- R6: Write address 3 bits 7:6 select when the shadow force is copied to the active force. 00 copies on a tick with the zero event, 01 on a tick with the period event, 10 on a tick with either, and 11 on every tick.
- R7: A force write changes no output by itself. On a tick that reloads the active force, the newly loaded force already decides the pin level on that same tick.
- R8: Action register 0x01A on A and 0x10A on B give normal polarity: high from zero or period until that output's compare-up event. 0x025 and 0x205 give the inverted wave.
- R9: After a force is cleared, the output keeps its last level until an event action changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled time-base tick, qualifies all events |
| evZero | input | 1 | Counter reached zero on this tick |
| evPeriod | input | 1 | Counter reached period on this tick |
| evCmpA | input | 1 | Compare A matched while counting up |
| evCmpB | input | 1 | Compare B matched while counting up |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write address |
| wrData | input | DATA_W | Register write data |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
The bench targets coincident events on one tick. A design with the wrong priority order would let a compare event or a zero event win over the period event. Where the higher-priority event has code 00, a design that stopped at the first event present would leave the pin unchanged instead of applying the next action. The bench walks through all four reload selections. A design that reloads the force on the wrong event would force the pin one event early or late. A design that applies the reloaded value one tick late would miss the level change on the reload tick. Event strobes without a tick, code 11 as "no force", and ignored upper bits of the action registers are also exercised. Getting any of these wrong would show up as an unexpected toggle or a spurious force.

// File: rtl/aqPkg.sv
package aqPkg;
  localparam int NUM_OUT = 2;
  localparam int NUM_EVT = 4;
  localparam int ACT_W   = 2;

  // event slots; slot order is independent of priority
  localparam int EV_ZERO   = 0;
  localparam int EV_PERIOD = 1;
  localparam int EV_CMPA   = 2;
  localparam int EV_CMPB   = 3;

  // bit positions decoded from the write data
  localparam int RLD_LSB = 6;
  localparam int FRC_W   = 2;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } action_e;

  typedef enum logic [1:0] {
    FRC_OFF  = 2'b00,
    FRC_LOW  = 2'b01,
    FRC_HIGH = 2'b10,
    FRC_OFF2 = 2'b11
  } force_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } reload_e;

  typedef struct packed {
    logic apply;
    logic evZero;
    logic evPeriod;
    logic evCmpA;
    logic evCmpB;
  } aqStrobe_t;

  function automatic int evtLsb(input int evt);
    case (evt)
      EV_ZERO:   return 0;
      EV_PERIOD: return 2;
      EV_CMPA:   return 4;
      default:   return 8;
    endcase
  endfunction
endpackage

// File: rtl/aqCtrl.sv
module aqCtrl
  import aqPkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int ADDR_W        = 2,
  parameter int ADDR_CTL_BASE = 0,
  parameter int ADDR_FORCE    = 2,
  parameter int ADDR_RELOAD   = 3
) (
  input  logic                                        clk,
  input  logic                                        rstN,
  input  logic                                        tick,
  input  logic                                        evZero,
  input  logic                                        evPeriod,
  input  logic                                        evCmpA,
  input  logic                                        evCmpB,
  input  logic                                        wrEn,
  input  logic [ADDR_W-1:0]                           wrAddr,
  input  logic [DATA_W-1:0]                           wrData,
  output aqStrobe_t                                   strobe,
  output logic [NUM_OUT-1:0][NUM_EVT-1:0][ACT_W-1:0]  actField,
  output logic [NUM_OUT-1:0][FRC_W-1:0]               effForce
);
  localparam int USED_W = evtLsb(EV_CMPB) + ACT_W;

  logic [NUM_OUT-1:0][FRC_W-1:0] shadowForce;
  logic [NUM_OUT-1:0][FRC_W-1:0] activeForce;
  logic [NUM_OUT-1:0][FRC_W-1:0] forceNext;
  reload_e                       reloadSel;
  logic                          reloadHit;
  logic                          loadNow;
  logic                          forceWr;
  logic                          reloadWr;
  logic                          unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:USED_W];
  assign forceWr      = wrEn && (wrAddr == ADDR_W'(ADDR_FORCE));
  assign reloadWr     = wrEn && (wrAddr == ADDR_W'(ADDR_RELOAD));

  // action field registers, one per output
  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : gCtl
    logic [NUM_EVT-1:0][ACT_W-1:0] fieldReg;
    logic                          ctlWr;
    assign ctlWr = wrEn && (wrAddr == ADDR_W'(ADDR_CTL_BASE + ch));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fieldReg <= '0;
      end else if (ctlWr) begin
        for (int e = 0; e < NUM_EVT; e++) begin
          fieldReg[e] <= wrData[evtLsb(e) +: ACT_W];
        end
      end
    end
    assign actField[ch] = fieldReg;
  end

  // reload point selection
  always_comb begin
    unique case (reloadSel)
      RLD_ZERO:   reloadHit = evZero;
      RLD_PERIOD: reloadHit = evPeriod;
      RLD_EITHER: reloadHit = evZero || evPeriod;
      default:    reloadHit = 1'b1;
    endcase
  end

  assign loadNow   = tick && reloadHit;
  assign forceNext = loadNow ? shadowForce : activeForce;
  assign effForce  = forceNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowForce <= '0;
      activeForce <= '0;
      reloadSel   <= RLD_ZERO;
    end else begin
      activeForce <= forceNext;
      if (forceWr) begin
        for (int ch = 0; ch < NUM_OUT; ch++) begin
          shadowForce[ch] <= wrData[ch*FRC_W +: FRC_W];
        end
      end
      if (reloadWr) begin
        reloadSel <= reload_e'(wrData[RLD_LSB +: 2]);
      end
    end
  end

  assign strobe.apply    = tick;
  assign strobe.evZero   = evZero;
  assign strobe.evPeriod = evPeriod;
  assign strobe.evCmpA   = evCmpA;
  assign strobe.evCmpB   = evCmpB;

  // active force only moves on a tick
  assert_force_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(activeForce));

  // immediate mode takes the shadow on any tick
  assert_reload_now_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && reloadSel == RLD_NOW) |=> activeForce == $past(shadowForce));

  // zero mode ignores ticks without a zero event
  assert_reload_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reloadSel == RLD_ZERO && !evZero) |=> $stable(activeForce));

  // period mode ignores ticks without a period event
  assert_reload_period_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reloadSel == RLD_PERIOD && !evPeriod) |=> $stable(activeForce));
endmodule

// File: rtl/aqDatapath.sv
module aqDatapath
  import aqPkg::*;
(
  input  logic                                        clk,
  input  logic                                        rstN,
  input  aqStrobe_t                                   strobe,
  input  logic [NUM_OUT-1:0][NUM_EVT-1:0][ACT_W-1:0]  actField,
  input  logic [NUM_OUT-1:0][FRC_W-1:0]               effForce,
  output logic [NUM_OUT-1:0]                          pwm
);
  for (genvar ch = 0; ch < NUM_OUT; ch++) begin : gOut
    action_e chosen;
    logic    nextLvl;
    logic    lvl;
    logic    forceOff;

    assign forceOff = !(effForce[ch] == FRC_LOW || effForce[ch] == FRC_HIGH);

    // later assignments win: period > zero > compare-B > compare-A
    always_comb begin
      chosen = ACT_NONE;
      if (strobe.evCmpA && actField[ch][EV_CMPA] != ACT_NONE)
        chosen = action_e'(actField[ch][EV_CMPA]);
      if (strobe.evCmpB && actField[ch][EV_CMPB] != ACT_NONE)
        chosen = action_e'(actField[ch][EV_CMPB]);
      if (strobe.evZero && actField[ch][EV_ZERO] != ACT_NONE)
        chosen = action_e'(actField[ch][EV_ZERO]);
      if (strobe.evPeriod && actField[ch][EV_PERIOD] != ACT_NONE)
        chosen = action_e'(actField[ch][EV_PERIOD]);
    end

    always_comb begin
      if (effForce[ch] == FRC_LOW) begin
        nextLvl = 1'b0;
      end else if (effForce[ch] == FRC_HIGH) begin
        nextLvl = 1'b1;
      end else begin
        unique case (chosen)
          ACT_LOW:    nextLvl = 1'b0;
          ACT_HIGH:   nextLvl = 1'b1;
          ACT_TOGGLE: nextLvl = ~lvl;
          default:    nextLvl = lvl;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)             lvl <= 1'b0;
      else if (strobe.apply) lvl <= nextLvl;
    end

    assign pwm[ch] = lvl;

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.apply |=> $stable(pwm[ch]));

    assert_force_low_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.apply && effForce[ch] == FRC_LOW) |=> !pwm[ch]);

    assert_force_high_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.apply && effForce[ch] == FRC_HIGH) |=> pwm[ch]);

    assert_period_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.apply && strobe.evPeriod && forceOff &&
       actField[ch][EV_PERIOD] == ACT_HIGH) |=> pwm[ch]);

    assert_zero_toggle_R2: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.apply && strobe.evZero && !strobe.evPeriod && forceOff &&
       actField[ch][EV_ZERO] == ACT_TOGGLE) |=> pwm[ch] != $past(pwm[ch]));
  end
endmodule

// File: rtl/pwmActionQual.sv
module pwmActionQual
  import aqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              evZero,
  input  logic              evPeriod,
  input  logic              evCmpA,
  input  logic              evCmpB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmA,
  output logic              pwmB
);
  aqStrobe_t                                  strobe;
  logic [NUM_OUT-1:0][NUM_EVT-1:0][ACT_W-1:0] actField;
  logic [NUM_OUT-1:0][FRC_W-1:0]              effForce;
  logic [NUM_OUT-1:0]                         pwm;

  aqCtrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .evZero   (evZero),
    .evPeriod (evPeriod),
    .evCmpA   (evCmpA),
    .evCmpB   (evCmpB),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobe   (strobe),
    .actField (actField),
    .effForce (effForce)
  );

  aqDatapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .actField (actField),
    .effForce (effForce),
    .pwm      (pwm)
  );

  assign pwmA = pwm[0];
  assign pwmB = pwm[1];
endmodule

// File: tb/tb_pwmActionQual.sv
module tb_pwmActionQual;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, evZero = 1'b0, evPeriod = 1'b0, evCmpA = 1'b0, evCmpB = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        pwmA, pwmB;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int mOut[2];
  int mShadow[2];
  int mActive[2];
  int mCtl[2];
  int mMode;
  int act;
  bit ld;

  always #4 clk = ~clk;

  pwmActionQual dut (
    .clk(clk), .rstN(rstN), .tick(tick), .evZero(evZero), .evPeriod(evPeriod),
    .evCmpA(evCmpA), .evCmpB(evCmpB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmA(pwmA), .pwmB(pwmB)
  );

  function automatic int fld(input int c, input int lsb);
    return (mCtl[c] >> lsb) & 3;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mOut[c] = 0; mShadow[c] = 0; mActive[c] = 0; mCtl[c] = 0;
      end
      mMode = 0;
    end else begin
      if (tick) begin
        ld = (mMode == 0 && evZero) || (mMode == 1 && evPeriod) ||
             (mMode == 2 && (evZero || evPeriod)) || (mMode == 3);
        if (ld) for (int c = 0; c < 2; c++) mActive[c] = mShadow[c];
        for (int c = 0; c < 2; c++) begin
          if (mActive[c] == 1) mOut[c] = 0;
          else if (mActive[c] == 2) mOut[c] = 1;
          else begin
            act = 0;
            if (evPeriod && fld(c, 2) != 0)    act = fld(c, 2);
            else if (evZero && fld(c, 0) != 0) act = fld(c, 0);
            else if (evCmpB && fld(c, 8) != 0) act = fld(c, 8);
            else if (evCmpA && fld(c, 4) != 0) act = fld(c, 4);
            if (act == 1) mOut[c] = 0;
            else if (act == 2) mOut[c] = 1;
            else if (act == 3) mOut[c] = 1 - mOut[c];
          end
        end
      end
      if (wrEn) begin
        case (wrAddr)
          2'd0: mCtl[0] = int'(wrData);
          2'd1: mCtl[1] = int'(wrData);
          2'd2: begin mShadow[0] = wrData & 3; mShadow[1] = (wrData >> 2) & 3; end
          default: mMode = (wrData >> 6) & 3;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (int'(pwmA) != mOut[0] || int'(pwmB) != mOut[1]) begin
        failures++;
        $display("FAIL %s model compare: actual A=%0d B=%0d expected A=%0d B=%0d",
                 tag, pwmA, pwmB, mOut[0], mOut[1]);
      end
    end
  end

  task automatic step(input bit t, input bit z, input bit p, input bit a, input bit b);
    @(negedge clk);
    tick = t; evZero = z; evPeriod = p; evCmpA = a; evCmpB = b;
    @(posedge clk); #1;
    tick = 0; evZero = 0; evPeriod = 0; evCmpA = 0; evCmpB = 0;
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wrEn = 1; wrAddr = 2'(addr); wrData = 16'(data);
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic chk(input string req, input bit expA, input bit expB);
    @(negedge clk);
    checks++;
    if (pwmA !== expA || pwmB !== expB) begin
      failures++;
      $display("FAIL %s directed: actual A=%0d B=%0d expected A=%0d B=%0d",
               req, pwmA, pwmB, expA, expB);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    tag = "R1"; chk("R1", 0, 0);
    wr(2, 'h2); step(1, 0, 1, 0, 0); chk("R1", 0, 0);     // default reload on zero only
    step(1, 1, 0, 0, 0); chk("R1", 1, 0);
    tag = "R9"; wr(2, 'h0); step(1, 1, 0, 0, 0); chk("R9", 1, 0);

    tag = "R8"; wr(3, 'hC0); wr(0, 'h01A); wr(1, 'h10A);
    step(1, 1, 0, 0, 0); chk("R8", 1, 1);
    step(1, 0, 0, 1, 0); chk("R8", 0, 1);
    step(1, 0, 0, 0, 1); chk("R8", 0, 0);
    step(1, 0, 1, 0, 0); chk("R8", 1, 1);
    tag = "R3"; wr(0, 'hFCDA); step(1, 0, 0, 1, 0); chk("R3", 0, 1);
    tag = "R8"; wr(0, 'h025); wr(1, 'h205);
    step(1, 1, 0, 0, 0); chk("R8", 0, 0);
    step(1, 0, 0, 0, 1); chk("R8", 0, 1);
    step(1, 0, 0, 1, 0); chk("R8", 1, 1);
    step(1, 0, 1, 0, 0); chk("R8", 0, 0);

    tag = "R2"; wr(0, 'h003); wr(1, 'h000);
    step(1, 1, 0, 0, 0); chk("R2", 1, 0);
    step(0, 1, 0, 0, 0); chk("R2", 1, 0);
    step(1, 1, 0, 0, 0); chk("R2", 0, 0);

    tag = "R4"; wr(0, 'h039); step(1, 1, 1, 0, 0); chk("R4", 1, 0);
    wr(0, 'h201); step(1, 1, 0, 0, 1); chk("R4", 0, 0);
    wr(0, 'h120); step(1, 0, 0, 1, 0); chk("R4", 1, 0);
    step(1, 0, 0, 1, 1); chk("R4", 0, 0);
    wr(0, 'h002); step(1, 1, 1, 0, 0); chk("R4", 1, 0);

    tag = "R5"; wr(2, 'h1); step(1, 1, 0, 0, 0); chk("R5", 0, 0);
    wr(2, 'h9); step(1, 1, 0, 0, 0); chk("R5", 0, 1);
    wr(2, 'hF); step(1, 1, 0, 0, 0); chk("R5", 1, 1);
    tag = "R7"; wr(2, 'h5); chk("R7", 1, 1);
    step(1, 0, 0, 0, 0); chk("R7", 0, 0);

    tag = "R6"; wr(2, 'h0); step(1, 0, 0, 0, 0); wr(0, 0); wr(1, 0);
    wr(3, 'h00); wr(2, 'hA);
    step(1, 0, 1, 0, 0); chk("R6", 0, 0);
    step(1, 1, 0, 0, 0); chk("R6", 1, 1);
    wr(3, 'h40); wr(2, 'h5);
    step(1, 1, 0, 0, 0); chk("R6", 1, 1);
    step(1, 0, 1, 0, 0); chk("R6", 0, 0);
    wr(3, 'h80); wr(2, 'h2);
    step(1, 0, 0, 1, 0); chk("R6", 0, 0);
    step(1, 1, 0, 0, 0); chk("R6", 1, 0);
    wr(2, 'h8); step(1, 0, 1, 0, 0); chk("R6", 1, 1);
    wr(3, 'hC0); wr(2, 'h1); step(1, 0, 0, 0, 0); chk("R6", 0, 1);

    // mixed traffic, checked against the model every clock
    tag = "R4";
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      seed = seed * 1103515245 + 12345;
      tick = seed[16]; evZero = seed[17]; evPeriod = seed[18] & seed[19];
      evCmpA = seed[20]; evCmpB = seed[21];
      wrEn = (seed[23:22] == 2'b00);
      wrAddr = seed[25:24];
      wrData = {seed[30:27], seed[11:0]};
    end
    @(negedge clk);
    tick = 0; evZero = 0; evPeriod = 0; evCmpA = 0; evCmpB = 0; wrEn = 0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule